// File: doc/BRIEF.md
# Multi-Beat Atomic Compare-and-Swap Engine

This block is the subordinate end of a write channel that takes atomic compare-and-swap requests made of several data beats. A request names a start address, a length field, a transfer size, a burst type and an atomic opcode. The data beats that follow carry two operands. The first half of the beats is the compare operand and the second half is the swap operand, each covering the same run of consecutive words.

The engine first collects every beat and checks the shape of the request. It then reads the addressed words from a small internal word store, one per cycle, and compares each one with its compare word. If every word matches, a second pass writes the swap words. If any word differs, nothing is written. The original contents then go back on a read-return channel, and a single write acknowledgement closes the transaction.

A request with an unsupported shape, a partial strobe or a misplaced last flag gets an error acknowledgement and leaves the store untouched. The request channel stays closed from acceptance until the acknowledgement has been taken.

Top module: `cas_burst_engine`

## Requirements
- R1: After reset, req_ready is 1 and dat_ready, ret_valid and ack_valid are 0. Word i of the store holds 32'hA000_0000 + i*32'h111.
- R2: A request is performed only if all of these hold: req_op is 6'b110001, req_burst is 2'b01 (incrementing), req_size is 3'b010 (4-byte beats), req_len is odd (so the beat count req_len+1 is even and at least 2), the beat count is at most MAX_BEATS, req_addr is 4-byte aligned, and the last addressed word lies inside the store. Any other request consumes req_len+1 beats and is answered with code 2'b10, with no return beats and no store update.
- R3: With N = req_len+1 beats, beats 0..N/2-1 are compare words for store words base..base+N/2-1 in ascending order, and beats N/2..N-1 are the swap words for the same words in the same order. Here base = req_addr/4.
- R4: The swap words are written only when every compare word equals its store word. A single mismatch leaves all addressed words unchanged. No word is written before all compare words have been checked.
- R5: A performed request returns N/2 beats on the return channel. They carry the pre-operation contents of words base upward, with ret_last high only on the final one. Then one acknowledgement with code 2'b00 follows, whether the compare matched or not.
- R6: dat_last must be high on beat N-1 and only there. If it comes early, collection stops at that beat. If it is missing, collection stops after beat N-1. Either way the answer is code 2'b10 with no return beats and no store update.
- R7: If any dat_strb bit is 0 on any beat, the answer is code 2'b10 with no return beats and no store update.
- R8: req_ready is 0 from the cycle after a request is accepted until the acknowledgement handshake completes.
- R9: While ret_valid or ack_valid is high and its ready is low, the valid stays high and the data, last flag or code stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request fields valid |
| req_ready | output | 1 | Engine can take a request |
| req_addr | input | 16 | Byte start address |
| req_len | input | 8 | Beat count minus one |
| req_size | input | 3 | Beat size code (log2 bytes) |
| req_burst | input | 2 | Burst type code |
| req_op | input | 6 | Atomic opcode |
| dat_valid | input | 1 | Data beat valid |
| dat_ready | output | 1 | Engine can take a data beat |
| dat_data | input | DATA_W | Beat payload |
| dat_strb | input | DATA_W/8 | Byte lane strobes |
| dat_last | input | 1 | Final beat flag |
| ret_valid | output | 1 | Return beat valid |
| ret_ready | input | 1 | Receiver takes a return beat |
| ret_data | output | DATA_W | Original word contents |
| ret_last | output | 1 | Final return beat |
| ack_valid | output | 1 | Acknowledgement valid |
| ack_ready | input | 1 | Receiver takes the acknowledgement |
| ack_code | output | 2 | 2'b00 success, 2'b10 error |

## Verification
On every cycle, assertions check the following: the request channel locks after acceptance, held return beats and acknowledgements stay stable under backpressure, only one channel phase is active at a time, collection ends with the data channel closed, and a store write happens only with a standing full match and no error. Other behaviour shows only in the bench's scenarios, where the expected values come from an independent model of the store. These are the split of beats into compare and swap halves, the all-or-nothing update on a partial mismatch, the returned pre-operation contents, and each shape, strobe and last-flag error leaving memory intact. A final read sweep over every word confirms that no rejected request wrote anything.

// File: rtl/cas_pkg.sv
package cas_pkg;

    localparam int ADDR_W  = 16;
    localparam int LEN_W   = 8;
    localparam int SIZE_W  = 3;
    localparam int BURST_W = 2;
    localparam int OP_W    = 6;

    localparam logic [OP_W-1:0]    OP_CMP_SWAP = 6'b110001;
    localparam logic [BURST_W-1:0] BURST_INCR  = 2'b01;
    localparam logic [1:0]         RESP_OKAY   = 2'b00;
    localparam logic [1:0]         RESP_SLVERR = 2'b10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_CMP,
        ST_SWP,
        ST_RET,
        ST_ACK
    } cas_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0]  addr;
        logic [LEN_W-1:0]   len;
        logic [SIZE_W-1:0]  size;
        logic [BURST_W-1:0] burst;
        logic [OP_W-1:0]    op;
    } cas_req_t;

    // Reset contents of store word idx
    function automatic logic [31:0] seed_word(input int unsigned idx);
        return 32'hA000_0000 + 32'(idx) * 32'h0000_0111;
    endfunction

    // True when the request has a shape the engine can perform
    function automatic logic req_shape_ok(input cas_req_t r,
                                          input int unsigned size_code,
                                          input int unsigned max_beats,
                                          input int unsigned mem_words);
        int unsigned beats;
        int unsigned base;
        int unsigned lane_mask;
        logic        ok;
        beats     = 32'(r.len) + 32'd1;
        base      = 32'(r.addr) >> size_code;
        lane_mask = (32'd1 << size_code) - 32'd1;
        ok = (r.op == OP_CMP_SWAP) && (r.burst == BURST_INCR);
        ok = ok && (32'(r.size) == size_code);
        ok = ok && (beats[0] == 1'b0) && (beats <= max_beats);
        ok = ok && ((32'(r.addr) & lane_mask) == 32'd0);
        ok = ok && (base + (beats >> 1) <= mem_words);
        return ok;
    endfunction

endpackage

// File: rtl/cas_word_store.sv
module cas_word_store
    import cas_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int MEM_WORDS = 16,
    localparam int WA_W     = $clog2(MEM_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WA_W-1:0]   rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [WA_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0] wr_data
);

    logic [DATA_W-1:0] words [MEM_WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MEM_WORDS; i++) begin
                words[i] <= DATA_W'(seed_word(i));
            end
        end else if (wr_en) begin
            words[wr_addr] <= wr_data;
        end
    end

    assign rd_data = words[rd_addr];

endmodule

// File: rtl/cas_beat_collector.sv
module cas_beat_collector
    import cas_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int MAX_BEATS = 8,
    localparam int IDX_W    = $clog2(MAX_BEATS),
    localparam int STRB_W   = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [LEN_W-1:0]  len,
    input  logic              dat_valid,
    input  logic              dat_ready,
    input  logic [DATA_W-1:0] dat_data,
    input  logic [STRB_W-1:0] dat_strb,
    input  logic              dat_last,
    input  logic [IDX_W-1:0]  sel_idx,
    input  logic [IDX_W-1:0]  half,
    output logic              beat_end,
    output logic              strb_err,
    output logic              last_err,
    output logic [DATA_W-1:0] cmp_word,
    output logic [DATA_W-1:0] swp_word
);

    localparam int CNT_W = LEN_W + 1;

    logic [DATA_W-1:0] beat_buf [MAX_BEATS];
    logic [CNT_W-1:0]  cnt_q;
    logic              strb_bad_q;
    logic              last_bad_q;
    logic              take;
    logic              is_final;
    logic              strb_bad_now;
    logic              last_bad_now;

    assign take         = dat_valid && dat_ready;
    assign is_final     = (cnt_q == {1'b0, len});
    assign strb_bad_now = take && !(&dat_strb);
    assign last_bad_now = take && (dat_last != is_final);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            strb_bad_q <= 1'b0;
            last_bad_q <= 1'b0;
        end else if (start) begin
            cnt_q      <= '0;
            strb_bad_q <= 1'b0;
            last_bad_q <= 1'b0;
        end else if (take) begin
            cnt_q <= cnt_q + CNT_W'(1);
            if (strb_bad_now) strb_bad_q <= 1'b1;
            if (last_bad_now) last_bad_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (take && (cnt_q < CNT_W'(MAX_BEATS))) begin
            beat_buf[cnt_q[IDX_W-1:0]] <= dat_data;
        end
    end

    assign beat_end = take && (dat_last || is_final);
    assign strb_err = strb_bad_q || strb_bad_now;
    assign last_err = last_bad_q || last_bad_now;
    assign cmp_word = beat_buf[sel_idx];
    assign swp_word = beat_buf[sel_idx + half];

    // R6
    collect_close_chk: assert property (@(posedge clk) disable iff (rst)
        beat_end |=> !dat_ready);

endmodule

// File: rtl/cas_seq_ctrl.sv
module cas_seq_ctrl
    import cas_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int MEM_WORDS = 16,
    parameter int MAX_BEATS = 8,
    localparam int IDX_W    = $clog2(MAX_BEATS),
    localparam int WA_W     = $clog2(MEM_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  cas_req_t          req_in,
    output logic              start,
    output logic [LEN_W-1:0]  len_out,
    output logic              dat_ready,
    input  logic              beat_end,
    input  logic              strb_err,
    input  logic              last_err,
    output logic [IDX_W-1:0]  sel_idx,
    output logic [IDX_W-1:0]  half,
    input  logic [DATA_W-1:0] cmp_word,
    input  logic [DATA_W-1:0] swp_word,
    output logic [WA_W-1:0]   mem_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              ret_valid,
    input  logic              ret_ready,
    output logic [DATA_W-1:0] ret_data,
    output logic              ret_last,
    output logic              ack_valid,
    input  logic              ack_ready,
    output logic [1:0]        ack_code
);

    localparam int SIZE_CODE = $clog2(DATA_W / 8);

    cas_state_e        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  len_q;
    logic              shape_bad_q;
    logic              err_q;
    logic              match_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] old_buf [MAX_BEATS];
    logic              last_idx;
    logic              word_eq;
    logic              any_err;

    assign half     = IDX_W'((32'(len_q) + 32'd1) >> 1);
    assign last_idx = (idx_q == half - IDX_W'(1));
    assign mem_addr = WA_W'(addr_q >> SIZE_CODE) + WA_W'(idx_q);
    assign word_eq  = (rd_data == cmp_word);
    assign any_err  = shape_bad_q || strb_err || last_err;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            addr_q      <= '0;
            len_q       <= '0;
            shape_bad_q <= 1'b0;
            err_q       <= 1'b0;
            match_q     <= 1'b0;
            idx_q       <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q      <= req_in.addr;
                        len_q       <= req_in.len;
                        shape_bad_q <= !req_shape_ok(req_in, SIZE_CODE,
                                                     MAX_BEATS, MEM_WORDS);
                        state_q     <= ST_COLLECT;
                    end
                end
                ST_COLLECT: begin
                    if (beat_end) begin
                        err_q   <= any_err;
                        match_q <= 1'b1;
                        idx_q   <= '0;
                        state_q <= any_err ? ST_ACK : ST_CMP;
                    end
                end
                ST_CMP: begin
                    if (!word_eq) match_q <= 1'b0;
                    if (last_idx) begin
                        idx_q   <= '0;
                        state_q <= (match_q && word_eq) ? ST_SWP : ST_RET;
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                    end
                end
                ST_SWP: begin
                    if (last_idx) begin
                        idx_q   <= '0;
                        state_q <= ST_RET;
                    end else begin
                        idx_q <= idx_q + IDX_W'(1);
                    end
                end
                ST_RET: begin
                    if (ret_ready) begin
                        if (last_idx) begin
                            idx_q   <= '0;
                            state_q <= ST_ACK;
                        end else begin
                            idx_q <= idx_q + IDX_W'(1);
                        end
                    end
                end
                ST_ACK: begin
                    if (ack_ready) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Capture of original contents during the compare pass
    always_ff @(posedge clk) begin
        if (state_q == ST_CMP) begin
            old_buf[idx_q] <= rd_data;
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign start     = req_valid && req_ready;
    assign len_out   = start ? req_in.len : len_q;
    assign dat_ready = (state_q == ST_COLLECT);
    assign sel_idx   = idx_q;
    assign mem_we    = (state_q == ST_SWP);
    assign mem_wdata = swp_word;
    assign ret_valid = (state_q == ST_RET);
    assign ret_data  = old_buf[idx_q];
    assign ret_last  = ret_valid && last_idx;
    assign ack_valid = (state_q == ST_ACK);
    assign ack_code  = err_q ? RESP_SLVERR : RESP_OKAY;

    // R8
    req_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R9
    ret_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ret_valid && !ret_ready) |=>
            (ret_valid && $stable(ret_data) && $stable(ret_last)));

    // R9
    ack_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && !ack_ready) |=> (ack_valid && $stable(ack_code)));

    // R4
    swap_gate_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (match_q && !err_q));

    // R5
    ret_then_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (ret_valid && ret_ready && ret_last) |=> ack_valid);

    // R1
    single_phase_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({req_ready, dat_ready, ret_valid, ack_valid}));

endmodule

// File: rtl/cas_burst_engine.sv
module cas_burst_engine
    import cas_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int MEM_WORDS = 16,
    parameter int MAX_BEATS = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [15:0]           req_addr,
    input  logic [7:0]            req_len,
    input  logic [2:0]            req_size,
    input  logic [1:0]            req_burst,
    input  logic [5:0]            req_op,
    input  logic                  dat_valid,
    output logic                  dat_ready,
    input  logic [DATA_W-1:0]     dat_data,
    input  logic [DATA_W/8-1:0]   dat_strb,
    input  logic                  dat_last,
    output logic                  ret_valid,
    input  logic                  ret_ready,
    output logic [DATA_W-1:0]     ret_data,
    output logic                  ret_last,
    output logic                  ack_valid,
    input  logic                  ack_ready,
    output logic [1:0]            ack_code
);

    localparam int IDX_W = $clog2(MAX_BEATS);
    localparam int WA_W  = $clog2(MEM_WORDS);

    cas_req_t          req_in;
    logic              start;
    logic [LEN_W-1:0]  len_cur;
    logic              beat_end;
    logic              strb_err;
    logic              last_err;
    logic [IDX_W-1:0]  sel_idx;
    logic [IDX_W-1:0]  half;
    logic [DATA_W-1:0] cmp_word;
    logic [DATA_W-1:0] swp_word;
    logic [WA_W-1:0]   mem_addr;
    logic [DATA_W-1:0] rd_data;
    logic              mem_we;
    logic [DATA_W-1:0] mem_wdata;

    assign req_in = '{addr: req_addr, len: req_len, size: req_size,
                      burst: req_burst, op: req_op};

    cas_seq_ctrl #(
        .DATA_W   (DATA_W),
        .MEM_WORDS(MEM_WORDS),
        .MAX_BEATS(MAX_BEATS)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_ready(req_ready),
        .req_in   (req_in),
        .start    (start),
        .len_out  (len_cur),
        .dat_ready(dat_ready),
        .beat_end (beat_end),
        .strb_err (strb_err),
        .last_err (last_err),
        .sel_idx  (sel_idx),
        .half     (half),
        .cmp_word (cmp_word),
        .swp_word (swp_word),
        .mem_addr (mem_addr),
        .rd_data  (rd_data),
        .mem_we   (mem_we),
        .mem_wdata(mem_wdata),
        .ret_valid(ret_valid),
        .ret_ready(ret_ready),
        .ret_data (ret_data),
        .ret_last (ret_last),
        .ack_valid(ack_valid),
        .ack_ready(ack_ready),
        .ack_code (ack_code)
    );

    cas_beat_collector #(
        .DATA_W   (DATA_W),
        .MAX_BEATS(MAX_BEATS)
    ) u_collect (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .len      (len_cur),
        .dat_valid(dat_valid),
        .dat_ready(dat_ready),
        .dat_data (dat_data),
        .dat_strb (dat_strb),
        .dat_last (dat_last),
        .sel_idx  (sel_idx),
        .half     (half),
        .beat_end (beat_end),
        .strb_err (strb_err),
        .last_err (last_err),
        .cmp_word (cmp_word),
        .swp_word (swp_word)
    );

    cas_word_store #(
        .DATA_W   (DATA_W),
        .MEM_WORDS(MEM_WORDS)
    ) u_store (
        .clk    (clk),
        .rst    (rst),
        .rd_addr(mem_addr),
        .rd_data(rd_data),
        .wr_en  (mem_we),
        .wr_addr(mem_addr),
        .wr_data(mem_wdata)
    );

endmodule

// File: tb/sim_cas_burst_engine.sv
module sim_cas_burst_engine;
    import cas_pkg::*;

    localparam int DW = 32;
    localparam int MW = 16;
    localparam int MB = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_len = '0;
    logic [2:0]  req_size = '0;
    logic [1:0]  req_burst = '0;
    logic [5:0]  req_op = '0;
    logic        dat_valid = 1'b0;
    logic        dat_ready;
    logic [31:0] dat_data = '0;
    logic [3:0]  dat_strb = '0;
    logic        dat_last = 1'b0;
    logic        ret_valid;
    logic        ret_ready = 1'b0;
    logic [31:0] ret_data;
    logic        ret_last;
    logic        ack_valid;
    logic        ack_ready = 1'b0;
    logic [1:0]  ack_code;

    always #5 clk = ~clk;

    cas_burst_engine #(.DATA_W(DW), .MEM_WORDS(MW), .MAX_BEATS(MB)) u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_len(req_len), .req_size(req_size), .req_burst(req_burst),
        .req_op(req_op),
        .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_data(dat_data),
        .dat_strb(dat_strb), .dat_last(dat_last),
        .ret_valid(ret_valid), .ret_ready(ret_ready), .ret_data(ret_data),
        .ret_last(ret_last),
        .ack_valid(ack_valid), .ack_ready(ack_ready), .ack_code(ack_code)
    );

    int          nchk = 0;
    int          nfail = 0;
    int          tick = 0;
    logic [31:0] model [MW];
    logic [31:0] tx [16];

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge
    task automatic send_req(input logic [15:0] a, input logic [7:0] l,
                            input logic [2:0] sz, input logic [1:0] b,
                            input logic [5:0] op);
        req_addr = a; req_len = l; req_size = sz; req_burst = b; req_op = op;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic send_beat(input logic [31:0] d, input logic [3:0] s,
                             input logic l);
        dat_data = d; dat_strb = s; dat_last = l; dat_valid = 1'b1;
        while (!dat_ready) @(negedge clk);
        @(negedge clk);
        dat_valid = 1'b0;
        dat_last = 1'b0;
    endtask

    task automatic collect_ret(input int n, input int base, input bit bp,
                               input string tag);
        int          got = 0;
        bit          stalled = 0;
        logic [31:0] held = '0;
        while (got < n) begin
            ret_ready = !(bp && (tick % 3 == 1));
            tick++;
            if (stalled) begin
                check({tag, " R9 ret_valid held"}, 32'(ret_valid), 32'd1);
                check({tag, " R9 ret_data held"}, ret_data, held);
            end
            if (ret_valid && ret_ready) begin
                check({tag, " R5 ret_data"}, ret_data, model[base + got]);
                check({tag, " R5 ret_last"}, 32'(ret_last), 32'(got == n - 1));
                got++;
                stalled = 0;
            end else if (ret_valid) begin
                stalled = 1;
                held = ret_data;
            end else begin
                stalled = 0;
            end
            @(negedge clk);
        end
        ret_ready = 1'b0;
    endtask

    task automatic get_ack(input logic [1:0] exp, input string tag,
                           input int hold, input bit no_ret);
        while (!ack_valid) begin
            if (no_ret && ret_valid) begin
                check({tag, " no return beat"}, 32'(ret_valid), 32'd0);
                ret_ready = 1'b1;
            end
            @(negedge clk);
        end
        ret_ready = 1'b0;
        for (int h = 0; h < hold; h++) begin
            ack_ready = 1'b0;
            check({tag, " R8 req_ready low while busy"}, 32'(req_ready), 32'd0);
            @(negedge clk);
            check({tag, " R9 ack_valid held"}, 32'(ack_valid), 32'd1);
        end
        ack_ready = 1'b1;
        check({tag, " ack_code"}, 32'(ack_code), 32'(exp));
        @(negedge clk);
        ack_ready = 1'b0;
        check({tag, " R8 req_ready after ack"}, 32'(req_ready), 32'd1);
    endtask

    // Performed request at word w with nb beats taken from tx
    task automatic run_ok(input int w, input int nb, input bit bp,
                          input int hold, input string tag);
        int half = nb / 2;
        bit match = 1;
        send_req(16'(w * 4), 8'(nb - 1), 3'b010, 2'b01, 6'b110001);
        check({tag, " R8 req_ready low after accept"}, 32'(req_ready), 32'd0);
        for (int k = 0; k < nb; k++) send_beat(tx[k], 4'hF, k == nb - 1);
        for (int i = 0; i < half; i++) if (tx[i] !== model[w + i]) match = 0;
        collect_ret(half, w, bp, tag);
        get_ack(RESP_OKAY, tag, hold, 0);
        if (match) for (int i = 0; i < half; i++) model[w + i] = tx[half + i];
    endtask

    task automatic run_err(input logic [15:0] a, input logic [7:0] l,
                           input logic [2:0] sz, input logic [1:0] b,
                           input logic [5:0] op, input int nsend,
                           input int bad_strb_at, input int last_at,
                           input string tag);
        send_req(a, l, sz, b, op);
        check({tag, " R8 req_ready low after accept"}, 32'(req_ready), 32'd0);
        for (int k = 0; k < nsend; k++)
            send_beat(tx[k], (k == bad_strb_at) ? 4'b1110 : 4'hF, k == last_at);
        get_ack(RESP_SLVERR, tag, 1, 1);
    endtask

    // Compare words equal to the store, swap words distinct
    task automatic fill_match(input int w, input int half);
        for (int i = 0; i < 16; i++) tx[i] = 32'hBAD0_0000 + 32'(i);
        for (int i = 0; i < half; i++)
            tx[i] = (w + i < MW) ? model[w + i] : 32'd0;
    endtask

    task automatic test_reset();
        check("R1 req_ready", 32'(req_ready), 32'd1);
        check("R1 dat_ready", 32'(dat_ready), 32'd0);
        check("R1 ret_valid", 32'(ret_valid), 32'd0);
        check("R1 ack_valid", 32'(ack_valid), 32'd0);
    endtask

    task automatic test_basic_match();
        tx[0] = model[0]; tx[1] = model[1];
        tx[2] = 32'h1111_0001; tx[3] = 32'h2222_0002;
        run_ok(0, 4, 0, 0, "R1/R3/R4 four-beat match");
        check("R4 model updated", model[1], 32'h2222_0002);
        tx[0] = ~model[0]; tx[1] = ~model[1]; tx[2] = 32'h0; tx[3] = 32'h0;
        run_ok(0, 4, 0, 0, "R4 readback after swap");
    endtask

    task automatic test_partial_mismatch();
        tx[0] = model[2]; tx[1] = model[3] ^ 32'h1;
        tx[2] = 32'h3333_0003; tx[3] = 32'h4444_0004;
        run_ok(2, 4, 0, 0, "R4 second word mismatch");
        tx[0] = ~model[2]; tx[1] = ~model[3]; tx[2] = 32'h0; tx[3] = 32'h0;
        run_ok(2, 4, 0, 0, "R4 no partial swap");
        check("R4 word 2 unchanged", model[2], 32'hA000_0000 + 32'h222);
    endtask

    task automatic test_wide_backpressure();
        for (int i = 0; i < 4; i++) begin
            tx[i] = model[8 + i];
            tx[4 + i] = 32'h5500_0000 + 32'(i);
        end
        run_ok(8, 8, 1, 3, "R3/R9 eight-beat match with stalls");
        for (int i = 0; i < 4; i++) begin
            tx[i] = ~model[8 + i];
            tx[4 + i] = 32'h0;
        end
        run_ok(8, 8, 1, 0, "R3 eight-beat swap order");
    endtask

    task automatic test_top_word();
        tx[0] = model[15]; tx[1] = 32'h7777_0015;
        run_ok(15, 2, 0, 0, "R2 last store word two-beat");
        check("R2 top word model", model[15], 32'h7777_0015);
    endtask

    task automatic test_shape_errors();
        fill_match(0, 2);
        run_err(16'h0000, 8'd2, 3'b010, 2'b01, 6'b110001, 3, -1, 2,
                "R2 odd beat count");
        fill_match(0, 2);
        run_err(16'h0000, 8'd3, 3'b010, 2'b00, 6'b110001, 4, -1, 3,
                "R2 non-incrementing burst");
        fill_match(0, 2);
        run_err(16'h0000, 8'd3, 3'b010, 2'b01, 6'b100000, 4, -1, 3,
                "R2 other opcode");
        fill_match(0, 2);
        run_err(16'h0000, 8'd3, 3'b001, 2'b01, 6'b110001, 4, -1, 3,
                "R2 wrong beat size");
        fill_match(14, 3);
        run_err(16'h0038, 8'd5, 3'b010, 2'b01, 6'b110001, 6, -1, 5,
                "R2 beyond store end");
        fill_match(0, 2);
        run_err(16'h0002, 8'd3, 3'b010, 2'b01, 6'b110001, 4, -1, 3,
                "R2 misaligned address");
        fill_match(0, 5);
        run_err(16'h0000, 8'd9, 3'b010, 2'b01, 6'b110001, 10, -1, 9,
                "R2 too many beats");
    endtask

    task automatic test_strobe_error();
        fill_match(1, 2);
        run_err(16'h0004, 8'd3, 3'b010, 2'b01, 6'b110001, 4, 3, 3,
                "R7 partial strobe");
    endtask

    task automatic test_last_errors();
        fill_match(1, 2);
        run_err(16'h0004, 8'd3, 3'b010, 2'b01, 6'b110001, 2, -1, 1,
                "R6 early last");
        fill_match(1, 2);
        run_err(16'h0004, 8'd3, 3'b010, 2'b01, 6'b110001, 4, -1, -1,
                "R6 missing last");
    endtask

    task automatic test_final_sweep();
        for (int g = 0; g < 4; g++) begin
            for (int i = 0; i < 4; i++) begin
                tx[i] = ~model[g * 4 + i];
                tx[4 + i] = 32'hDEAD_0000 + 32'(i);
            end
            run_ok(g * 4, 8, 0, 0, "R2/R6/R7 store unchanged sweep");
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog all requirements act=hung exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        for (int i = 0; i < MW; i++) model[i] = 32'hA000_0000 + 32'(i) * 32'h111;
        for (int i = 0; i < 16; i++) tx[i] = '0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_basic_match();
        test_partial_mismatch();
        test_wide_backpressure();
        test_top_word();
        test_shape_errors();
        test_strobe_error();
        test_last_errors();
        test_final_sweep();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule